// File: doc/BRIEF.md
# Program-Indexed Datapath Capture Unit

This unit watches the datapath of an audio signal processor and takes a snapshot of one internal value each time the instruction sequencer reaches a chosen program step. It has eight capture slots. Each slot holds a setup word, made of a program-step index and a 2-bit tap code. When the live program counter equals that index, the slot latches the chosen tap. The tap is a 28-bit signed fixed-point value with 23 fraction bits. The slot truncates it to a 24-bit value with 19 fraction bits before storing it.

Setup words arrive over a simple write bus. A newly written setup word is held in a staging copy and only becomes active at the start of the next program cycle, so an index and a tap code from different writes can never act together. Six slots are read back over the control port. The other two slots drive dedicated outputs that feed the digital-out path.

Top module: `pc_capture_unit`

## Requirements
- R1: After reset every captured value is zero: `rd_data`, `dout_a` and `dout_b` all read 0.
- R2: A slot captures when `step_vld` is high and `pc` equals the slot's active index. The new value is visible from the next clock edge onward and is held until the next match. A match on a later program pass replaces the value.
- R3: Tap code 0 selects `tap_mulx`, 1 selects `tap_muly`, 2 selects `tap_mac` and 3 selects `tap_fb`.
- R4: The stored value is the selected 28-bit tap with its four least significant bits dropped (tap bits 27..4), so the sign is kept.
- R5: The setup word on `wr_data` has the tap code in bits 1..0 and the program-step index in bits 12..2. Slot k (k = 0..7) is written when `wr_en` is high and `wr_addr` = 2634 + k.
- R6: A setup write takes effect at the next `pgm_start` cycle that follows the write, and is used from that cycle's own step onward. A write made in the same cycle as `pgm_start`, or at any point inside a program cycle, leaves that program cycle on the old setup.
- R7: `rd_data` returns the value of slot k when `rd_addr` = 2634 + k for k = 0..5. Every other address, including 2640 and 2641, reads 0.
- R8: Slot 6 drives `dout_a` and slot 7 drives `dout_b`.
- R9: Slots that share the same index capture in the same step, each from its own tap.
- R10: While `step_vld` is low, no captured value changes, whatever `pc` shows.
- R11: A write to an address outside 2634..2641 changes no slot's setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pgm_start | input | 1 | First step of a program cycle; loads staged setups |
| step_vld | input | 1 | A program step executes this cycle |
| pc | input | 11 | Live program counter |
| tap_mulx | input | 28 | Multiplier X operand tap |
| tap_muly | input | 28 | Multiplier Y operand tap |
| tap_mac | input | 28 | Multiply-accumulate result tap |
| tap_fb | input | 28 | Accumulator feedback tap |
| wr_en | input | 1 | Setup write strobe |
| wr_addr | input | 12 | Setup write address |
| wr_data | input | 13 | Setup word {index, tap code} |
| rd_addr | input | 12 | Readback address |
| rd_data | output | 24 | Captured value of the addressed control-port slot |
| dout_a | output | 24 | Captured value of slot 6 |
| dout_b | output | 24 | Captured value of slot 7 |

## Verification
A setup write can land in the same cycle as the start of a program cycle, which is also the cycle in which the staged setups are promoted. The bench provokes this by writing a slot's setup exactly on the `pgm_start` step, and again in the middle of a program cycle. It then checks that the pass in progress still captures with the old index and tap, and that the following pass uses the new pair. A second collision is a match on the very first step of a pass, where the freshly promoted setup must already be the one that decides. This case is judged through a slot whose index is 0.

// File: rtl/pc_capture_unit.sv
module pc_capture_unit #(
  parameter int PC_W      = 11,
  parameter int TAP_W     = 28,
  parameter int DROP_W    = 4,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 2634,
  parameter int NUM_CTRL  = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pgm_start,
  input  logic                       step_vld,
  input  logic [PC_W-1:0]            pc,
  input  logic [TAP_W-1:0]           tap_mulx,
  input  logic [TAP_W-1:0]           tap_muly,
  input  logic [TAP_W-1:0]           tap_mac,
  input  logic [TAP_W-1:0]           tap_fb,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [PC_W+1:0]            wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [TAP_W-DROP_W-1:0]    rd_data,
  output logic [TAP_W-DROP_W-1:0]    dout_a,
  output logic [TAP_W-DROP_W-1:0]    dout_b
);
  localparam int CAP_W     = TAP_W - DROP_W;
  localparam int SETUP_W   = PC_W + 2;
  localparam int NUM_SLOTS = NUM_CTRL + 2;

  logic [CAP_W-1:0] cap_all [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [SETUP_W-1:0] staged_q, active_q;
    logic [SETUP_W-1:0] eff;
    logic [TAP_W-1:0]   tap;
    logic [CAP_W-1:0]   cap_q;
    logic               hit_wr, hit_pc;

    assign hit_wr = wr_en && (wr_addr == ADDR_W'(BASE_ADDR + i));
    assign eff    = pgm_start ? staged_q : active_q;
    assign hit_pc = step_vld && (pc == eff[SETUP_W-1:2]);

    always_comb begin
      case (eff[1:0])
        2'd0:    tap = tap_mulx;
        2'd1:    tap = tap_muly;
        2'd2:    tap = tap_mac;
        default: tap = tap_fb;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        staged_q <= '0;
        active_q <= '0;
        cap_q    <= '0;
      end else begin
        if (hit_wr)    staged_q <= wr_data;
        if (pgm_start) active_q <= staged_q;
        if (hit_pc)    cap_q    <= tap[TAP_W-1:DROP_W];
      end
    end

    assign cap_all[i] = cap_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (rd_addr == ADDR_W'(BASE_ADDR + i)) rd_data = cap_all[i];
  end

  assign dout_a = cap_all[NUM_CTRL];
  assign dout_b = cap_all[NUM_CTRL+1];
endmodule

// File: rtl/pc_capture_unit_chk.sv
module pc_capture_unit_chk #(
  parameter int ADDR_W    = 12,
  parameter int CAP_W     = 24,
  parameter int BASE_ADDR = 2634,
  parameter int NUM_CTRL  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_vld,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [CAP_W-1:0]  rd_data,
  input logic [CAP_W-1:0]  dout_a,
  input logic [CAP_W-1:0]  dout_b
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (dout_a == '0 && dout_b == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_vld |=> ($stable(dout_a) && $stable(dout_b)));

  // R2
  change_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_a != $past(dout_a) || dout_b != $past(dout_b)) |-> $past(step_vld));

  // R7
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_addr) < BASE_ADDR || int'(rd_addr) >= BASE_ADDR + NUM_CTRL) |-> rd_data == '0);
endmodule

bind pc_capture_unit pc_capture_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .step_vld(step_vld), .rd_addr(rd_addr),
  .rd_data(rd_data), .dout_a(dout_a), .dout_b(dout_b)
);

// File: tb/pc_capture_unit_tb.sv
module pc_capture_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 2634;

  logic        clk = 0, rst_n = 0, pgm_start = 0, step_vld = 0, wr_en = 0;
  logic [10:0] pc = '0;
  logic [27:0] tap_mulx = '0, tap_muly = '0, tap_mac = '0, tap_fb = '0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [12:0] wr_data = '0;
  logic [23:0] rd_data, dout_a, dout_b;

  int n_cmp = 0, n_bad = 0, run_id = 0, cycles = 0;
  bit done = 0;
  int   m_idx [8];
  int   m_sel [8];
  logic [23:0] m_cap [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_capture_unit dut_i (
    .clk(clk), .rst_n(rst_n), .pgm_start(pgm_start), .step_vld(step_vld), .pc(pc),
    .tap_mulx(tap_mulx), .tap_muly(tap_muly), .tap_mac(tap_mac), .tap_fb(tap_fb),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .dout_a(dout_a), .dout_b(dout_b)
  );

  function automatic logic [27:0] tapv(int sel, int p, int run);
    logic [31:0] v;
    v = (32'(p) * 32'h00A5C3B1 + 32'(sel) * 32'h03D0F00D + 32'(run) * 32'h0456789B) ^ 32'h0F00000F;
    return v[27:0];
  endfunction

  task automatic cmp(string req, logic [23:0] act, logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_slot(int s, string req);
    logic [23:0] got;
    if (s < 6) begin
      rd_addr = 12'(BASE + s);
      #1 got = rd_data;
    end else got = (s == 6) ? dout_a : dout_b;
    cmp(req, got, m_cap[s]);
  endtask

  task automatic check_all(string req);
    for (int s = 0; s < 8; s++) check_slot(s, req);
  endtask

  task automatic write_setup(int addr, int idx, int sel);
    @(negedge clk);
    wr_en = 1; wr_addr = 12'(addr); wr_data = {11'(idx), 2'(sel)};
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_slot(int s, int idx, int sel);
    write_setup(BASE + s, idx, sel);
  endtask

  // one program pass; optional setup write at step wstep; model uses setups active for the pass
  task automatic run_program(int len, int wstep, int ws, int widx, int wsel);
    int a_idx [8];
    int a_sel [8];
    run_id++;
    for (int s = 0; s < 8; s++) begin a_idx[s] = m_idx[s]; a_sel[s] = m_sel[s]; end
    for (int p = 0; p < len; p++) begin
      @(negedge clk);
      wr_en = 0;
      pc = 11'(p); step_vld = 1; pgm_start = (p == 0);
      tap_mulx = tapv(0, p, run_id); tap_muly = tapv(1, p, run_id);
      tap_mac  = tapv(2, p, run_id); tap_fb   = tapv(3, p, run_id);
      if (p == wstep) begin
        wr_en = 1; wr_addr = 12'(BASE + ws); wr_data = {11'(widx), 2'(wsel)};
        m_idx[ws] = widx; m_sel[ws] = wsel;
      end
      for (int s = 0; s < 8; s++)
        if (a_idx[s] == p) m_cap[s] = tapv(a_sel[s], p, run_id) >> 4;
    end
    @(negedge clk);
    wr_en = 0; step_vld = 0; pgm_start = 0;
  endtask

  task automatic t_reset;
    for (int s = 0; s < 8; s++) begin m_idx[s] = 0; m_sel[s] = 0; m_cap[s] = '0; end
    check_all("R1 reset");
  endtask

  task automatic t_basic;
    int ix [8] = '{5, 5, 9, 20, 0, 31, 3, 12};
    int sl [8] = '{0, 1, 2, 3, 2, 0, 2, 3};
    for (int s = 0; s < 8; s++) begin
      set_slot(s, ix[s], sl[s]); m_idx[s] = ix[s]; m_sel[s] = sl[s];
    end
    run_program(32, -1, 0, 0, 0);
    check_slot(0, "R3 code0 mulx");
    check_slot(1, "R9 shared index, R3 code1 muly");
    check_slot(2, "R3 code2 mac");
    check_slot(3, "R3 code3 fb");
    check_slot(4, "R2 match on first step");
    check_slot(5, "R5 index field bits 12..2");
    cmp("R8 slot6 on dout_a", dout_a, m_cap[6]);
    cmp("R8 slot7 on dout_b", dout_b, m_cap[7]);
  endtask

  task automatic t_trunc;
    logic [27:0] v;
    v = tapv(m_sel[3], m_idx[3], run_id);
    rd_addr = 12'(BASE + 3);
    #1 cmp("R4 drop four LSBs", rd_data, v[27:4]);
  endtask

  task automatic t_repeat_and_idle;
    run_program(32, -1, 0, 0, 0);
    check_all("R2 update on later pass");
    @(negedge clk);
    pc = 11'd12; step_vld = 0; tap_fb = 28'h0FFFFFF; tap_mac = 28'h0ABCDEF;
    repeat (3) @(negedge clk);
    check_all("R10 no capture while step_vld low");
  endtask

  task automatic t_defer;
    run_program(32, 2, 0, 7, 3);
    check_slot(0, "R6 mid-pass write deferred");
    run_program(32, -1, 0, 0, 0);
    check_slot(0, "R6 new setup on next pass");
    run_program(32, 0, 1, 11, 2);
    check_slot(1, "R6 write on pgm_start step deferred");
    run_program(32, -1, 0, 0, 0);
    check_slot(1, "R6 write on pgm_start applied next pass");
  endtask

  task automatic t_bad_addr;
    write_setup(BASE - 1, 4, 1);
    write_setup(BASE + 8, 4, 1);
    write_setup(0, 4, 1);
    run_program(32, -1, 0, 0, 0);
    check_all("R11 out-of-range writes ignored");
    rd_addr = 12'(BASE + 6); #1 cmp("R7 addr 2640 reads 0", rd_data, '0);
    rd_addr = 12'(BASE + 7); #1 cmp("R7 addr 2641 reads 0", rd_data, '0);
    rd_addr = 12'(BASE - 1); #1 cmp("R7 addr 2633 reads 0", rd_data, '0);
    rd_addr = 12'(BASE + 5); #1 cmp("R7 addr 2639 reads slot5", rd_data, m_cap[5]);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_trunc();
    t_repeat_and_idle();
    t_defer();
    t_bad_addr();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule